// File: doc/BRIEF.md
# Floating-Point Exception Status Register

This block is the status and control word that sits next to a floating-point unit. The unit pulses a completion strobe at the end of each operation. With that strobe it reports five exception indications: underflow, divide-by-zero, overflow, invalid operation and unimplemented operation. It also reports whether an operand was denormalized. The register keeps these indications as cause bits that describe the latest operation only. It also keeps sticky flags that collect exceptions which were masked and so did not trap.

Software reads and writes the whole 32-bit word through a single-cycle port. Through that port it sets the per-exception enable masks, the denormal-handling control and the two-bit rounding mode, which is driven straight to the arithmetic unit. Software can clear cause bits and sticky flags, but it can never set them. When a completed operation reports an exception whose enable bit is set, the block raises a one-cycle trap request to the processor.

Top module: `fpx_status_reg`

## Requirements
- R1: After reset every field is 0: the read value is 0x0000_0000, the rounding mode output is 00 (round to nearest) and the trap request is low.
- R2: In the cycle after a completion strobe, the cause bits (bit 26 underflow, 27 divide-by-zero, 28 overflow, 29 invalid, 25 unimplemented) equal that operation's exceptions only; earlier cause values are gone.
- R3: A software write of 0 to a cause bit or a sticky flag (bits 8..12 for underflow, divide-by-zero, overflow, invalid, unimplemented) clears it; a write of 1 leaves it unchanged and never sets it.
- R4: Bits 31:30 hold the rounding mode, written and read by software and driven on round_mode_o: 00 nearest, 01 toward zero, 10 toward +infinity, 11 toward -infinity. Bit 23 (denormal pass control) and the enables at bits 17..21 (underflow, divide-by-zero, overflow, invalid, unimplemented) are plain read/write.
- R5: trap_req_o is high for exactly the cycle after a completion strobe in which at least one reported exception has its enable bit set. It is low in every other cycle.
- R6: When a completion strobe reports exceptions and none of them is enabled, the matching sticky flags are set. They stay set across later operations until software clears them.
- R7: When a completion strobe raises a trap, no sticky flag is set by that operation. This applies even if another exception in the same operation was masked.
- R8: With bit 23 at 0, a denormalized-operand indication raises the unimplemented exception. With bit 23 at 1, it raises nothing.
- R9: When a software write and a completion strobe fall in the same cycle, the cause bits take the operation's result and any sticky flag set by the operation stays set. Enables, control and rounding mode take the written value.
- R10: Reserved bits (all bits outside 8..12, 17..21, 23, 25..31) always read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fpu_done_i | input | 1 | Operation-completion strobe from the arithmetic unit |
| fpu_underflow_i | input | 1 | Completed operation underflowed |
| fpu_divzero_i | input | 1 | Completed operation divided by zero |
| fpu_overflow_i | input | 1 | Completed operation overflowed |
| fpu_invalid_i | input | 1 | Completed operation was invalid |
| fpu_unimpl_i | input | 1 | Completed operation is not implemented |
| fpu_denorm_i | input | 1 | Completed operation had a denormalized operand |
| csr_we_i | input | 1 | Software write enable |
| csr_wdata_i | input | 32 | Software write data |
| csr_rdata_o | output | 32 | Current register value |
| round_mode_o | output | 2 | Rounding mode to the arithmetic unit |
| denorm_pass_o | output | 1 | Denormal pass control to the arithmetic unit |
| trap_req_o | output | 1 | One-cycle exception trap request |

## Verification
All state can be read through csr_rdata_o, so a wrong cause, sticky or enable bit shows up on the read port in the cycle right after the edge that stored it. A wrong trap decision shows up on trap_req_o in that same cycle. A sticky flag that was set wrongly stays visible across the following operations. A cause bit that was wrong is overwritten at the next strobe, so each cycle's read value is checked against a model, not only the final state. Collisions between a write and a strobe are the main hazard. They are driven both directed and at random, because a wrong priority corrupts only the bits that the write and the operation both touch.

// File: rtl/fpx_status_pkg.sv
package fpx_status_pkg;

    localparam int XLEN  = 32;
    localparam int NLANE = 5;
    localparam int RM_W  = 2;

    // exception lane order
    localparam int L_UF = 0;
    localparam int L_DZ = 1;
    localparam int L_OV = 2;
    localparam int L_IV = 3;
    localparam int L_UI = 4;

    // field placement
    localparam int STICKY_LSB = 8;
    localparam int ENABLE_LSB = 17;
    localparam int DN_POS     = 23;
    localparam int RM_LSB     = XLEN - RM_W;

    // cause bit position of a lane
    function automatic int cause_pos(int lane);
        case (lane)
            L_UF:    return 26;
            L_DZ:    return 27;
            L_OV:    return 28;
            L_IV:    return 29;
            default: return 25;
        endcase
    endfunction

    typedef struct packed {
        logic [RM_W-1:0]  rm;
        logic             dn;
        logic [NLANE-1:0] enable;
        logic [NLANE-1:0] cause;
        logic [NLANE-1:0] sticky;
        logic             trap;
    } fpx_state_t;

endpackage

// File: rtl/fpx_exc_capture.sv
module fpx_exc_capture
    import fpx_status_pkg::*;
(
    input  logic             uf_i,
    input  logic             dz_i,
    input  logic             ov_i,
    input  logic             iv_i,
    input  logic             ui_i,
    input  logic             denorm_i,
    input  logic             dn_i,
    output logic [NLANE-1:0] exc_o
);

    always_comb begin
        exc_o       = '0;
        exc_o[L_UF] = uf_i;
        exc_o[L_DZ] = dz_i;
        exc_o[L_OV] = ov_i;
        exc_o[L_IV] = iv_i;
        // denormal operand without pass control counts as unimplemented
        exc_o[L_UI] = ui_i | (denorm_i & ~dn_i);
    end

endmodule

// File: rtl/fpx_exc_lane.sv
module fpx_exc_lane (
    input  logic done_i,
    input  logic exc_i,
    input  logic en_i,
    input  logic trap_take_i,
    input  logic we_i,
    input  logic wr_cause_i,
    input  logic wr_sticky_i,
    input  logic cause_q_i,
    input  logic sticky_q_i,
    output logic cause_d_o,
    output logic sticky_d_o,
    output logic hit_o
);

    logic sticky_keep;
    logic sticky_set;

    always_comb begin
        hit_o = exc_i & en_i;

        // operation result outranks a software clear
        if (done_i) begin
            cause_d_o = exc_i;
        end else if (we_i) begin
            cause_d_o = cause_q_i & wr_cause_i;
        end else begin
            cause_d_o = cause_q_i;
        end

        sticky_keep = we_i ? (sticky_q_i & wr_sticky_i) : sticky_q_i;
        sticky_set  = done_i & ~trap_take_i & exc_i;
        sticky_d_o  = sticky_keep | sticky_set;
    end

endmodule

// File: rtl/fpx_csr_map.sv
module fpx_csr_map
    import fpx_status_pkg::*;
(
    input  logic [RM_W-1:0]  rm_i,
    input  logic             dn_i,
    input  logic [NLANE-1:0] enable_i,
    input  logic [NLANE-1:0] cause_i,
    input  logic [NLANE-1:0] sticky_i,
    input  logic [XLEN-1:0]  wdata_i,
    output logic [XLEN-1:0]  rdata_o,
    output logic [RM_W-1:0]  w_rm_o,
    output logic             w_dn_o,
    output logic [NLANE-1:0] w_enable_o,
    output logic [NLANE-1:0] w_cause_o,
    output logic [NLANE-1:0] w_sticky_o
);

    always_comb begin
        rdata_o = '0;
        for (int l = 0; l < NLANE; l++) begin
            rdata_o[cause_pos(l)]    = cause_i[l];
            rdata_o[STICKY_LSB + l]  = sticky_i[l];
            rdata_o[ENABLE_LSB + l]  = enable_i[l];
        end
        rdata_o[DN_POS]           = dn_i;
        rdata_o[RM_LSB +: RM_W]   = rm_i;
    end

    always_comb begin
        for (int l = 0; l < NLANE; l++) begin
            w_cause_o[l] = 1'(wdata_i >> cause_pos(l));
        end
        w_sticky_o = NLANE'(wdata_i >> STICKY_LSB);
        w_enable_o = NLANE'(wdata_i >> ENABLE_LSB);
        w_dn_o     = 1'(wdata_i >> DN_POS);
        w_rm_o     = RM_W'(wdata_i >> RM_LSB);
    end

endmodule

// File: rtl/fpx_status_reg.sv
module fpx_status_reg
    import fpx_status_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        fpu_done_i,
    input  logic        fpu_underflow_i,
    input  logic        fpu_divzero_i,
    input  logic        fpu_overflow_i,
    input  logic        fpu_invalid_i,
    input  logic        fpu_unimpl_i,
    input  logic        fpu_denorm_i,
    input  logic        csr_we_i,
    input  logic [31:0] csr_wdata_i,
    output logic [31:0] csr_rdata_o,
    output logic [1:0]  round_mode_o,
    output logic        denorm_pass_o,
    output logic        trap_req_o
);

    fpx_state_t st_q, st_d;

    logic [NLANE-1:0] exc;
    logic [NLANE-1:0] lane_hit;
    logic [NLANE-1:0] lane_cause_d;
    logic [NLANE-1:0] lane_sticky_d;
    logic [NLANE-1:0] w_cause;
    logic [NLANE-1:0] w_sticky;
    logic [NLANE-1:0] w_enable;
    logic             w_dn;
    logic [RM_W-1:0]  w_rm;
    logic             trap_take;

    fpx_exc_capture u_capture (
        .uf_i     (fpu_underflow_i),
        .dz_i     (fpu_divzero_i),
        .ov_i     (fpu_overflow_i),
        .iv_i     (fpu_invalid_i),
        .ui_i     (fpu_unimpl_i),
        .denorm_i (fpu_denorm_i),
        .dn_i     (st_q.dn),
        .exc_o    (exc)
    );

    fpx_csr_map u_map (
        .rm_i       (st_q.rm),
        .dn_i       (st_q.dn),
        .enable_i   (st_q.enable),
        .cause_i    (st_q.cause),
        .sticky_i   (st_q.sticky),
        .wdata_i    (csr_wdata_i),
        .rdata_o    (csr_rdata_o),
        .w_rm_o     (w_rm),
        .w_dn_o     (w_dn),
        .w_enable_o (w_enable),
        .w_cause_o  (w_cause),
        .w_sticky_o (w_sticky)
    );

    assign trap_take = fpu_done_i & (|lane_hit);

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        fpx_exc_lane u_lane (
            .done_i      (fpu_done_i),
            .exc_i       (exc[g]),
            .en_i        (st_q.enable[g]),
            .trap_take_i (trap_take),
            .we_i        (csr_we_i),
            .wr_cause_i  (w_cause[g]),
            .wr_sticky_i (w_sticky[g]),
            .cause_q_i   (st_q.cause[g]),
            .sticky_q_i  (st_q.sticky[g]),
            .cause_d_o   (lane_cause_d[g]),
            .sticky_d_o  (lane_sticky_d[g]),
            .hit_o       (lane_hit[g])
        );
    end

    always_comb begin
        st_d        = st_q;
        st_d.cause  = lane_cause_d;
        st_d.sticky = lane_sticky_d;
        st_d.trap   = trap_take;
        if (csr_we_i) begin
            st_d.enable = w_enable;
            st_d.dn     = w_dn;
            st_d.rm     = w_rm;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign round_mode_o  = st_q.rm;
    assign denorm_pass_o = st_q.dn;
    assign trap_req_o    = st_q.trap;

endmodule

// File: rtl/fpx_status_reg_chk.sv
module fpx_status_reg_chk (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        fpu_done_i,
    input logic        fpu_underflow_i,
    input logic        fpu_divzero_i,
    input logic        fpu_overflow_i,
    input logic        fpu_invalid_i,
    input logic        fpu_unimpl_i,
    input logic        fpu_denorm_i,
    input logic [31:0] csr_rdata_o,
    input logic [1:0]  round_mode_o,
    input logic        trap_req_o
);

    localparam logic [31:0] CAUSE_M  = 32'h3E00_0000;
    localparam logic [31:0] STICKY_M = 32'h0000_1F00;
    localparam logic [31:0] FLAG_M   = CAUSE_M | STICKY_M;
    localparam logic [31:0] RSV_M    = 32'h0141_E0FF;

    logic no_exc;
    assign no_exc = !(fpu_underflow_i | fpu_divzero_i | fpu_overflow_i |
                      fpu_invalid_i | fpu_unimpl_i | fpu_denorm_i);

    p_trap_needs_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_req_o |-> $past(fpu_done_i));

    p_cause_wiped_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fpu_done_i && no_exc) |=> ((csr_rdata_o & CAUSE_M) == 32'h0));

    p_no_sw_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !fpu_done_i |=> (((csr_rdata_o & FLAG_M) & ~$past(csr_rdata_o & FLAG_M)) == 32'h0));

    p_sticky_frozen_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        trap_req_o |-> (((csr_rdata_o & STICKY_M) & ~$past(csr_rdata_o & STICKY_M)) == 32'h0));

    p_denorm_unimpl_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fpu_done_i && fpu_denorm_i && !csr_rdata_o[23]) |=> csr_rdata_o[25]);

    p_rm_port_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        round_mode_o == 2'(csr_rdata_o >> 30));

    p_reserved_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_rdata_o & RSV_M) == 32'h0);

endmodule

bind fpx_status_reg fpx_status_reg_chk u_chk (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .fpu_done_i      (fpu_done_i),
    .fpu_underflow_i (fpu_underflow_i),
    .fpu_divzero_i   (fpu_divzero_i),
    .fpu_overflow_i  (fpu_overflow_i),
    .fpu_invalid_i   (fpu_invalid_i),
    .fpu_unimpl_i    (fpu_unimpl_i),
    .fpu_denorm_i    (fpu_denorm_i),
    .csr_rdata_o     (csr_rdata_o),
    .round_mode_o    (round_mode_o),
    .trap_req_o      (trap_req_o)
);

// File: tb/fpx_status_reg_tb.sv
`timescale 1ns/1ps
module fpx_status_reg_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        done = 1'b0;
    logic        uf = 1'b0, dz = 1'b0, ov = 1'b0, iv = 1'b0, ui = 1'b0, dnm = 1'b0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [1:0]  rm_out;
    logic        dn_out;
    logic        trap;

    int n_chk  = 0;
    int n_fail = 0;

    // model state, lanes: 0 UF, 1 DZ, 2 OV, 3 IV, 4 UI
    logic [4:0] m_cause = '0, m_sticky = '0, m_en = '0;
    logic       m_dn = 1'b0;
    logic [1:0] m_rm = 2'b00;
    logic       m_trap = 1'b0;

    always #2 clk = ~clk;

    fpx_status_reg u_dut (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .fpu_done_i      (done),
        .fpu_underflow_i (uf),
        .fpu_divzero_i   (dz),
        .fpu_overflow_i  (ov),
        .fpu_invalid_i   (iv),
        .fpu_unimpl_i    (ui),
        .fpu_denorm_i    (dnm),
        .csr_we_i        (we),
        .csr_wdata_i     (wdata),
        .csr_rdata_o     (rdata),
        .round_mode_o    (rm_out),
        .denorm_pass_o   (dn_out),
        .trap_req_o      (trap)
    );

    function automatic logic [31:0] exp_word();
        logic [31:0] r = '0;
        r[31:30] = m_rm;
        r[29]    = m_cause[3];
        r[28]    = m_cause[2];
        r[27]    = m_cause[1];
        r[26]    = m_cause[0];
        r[25]    = m_cause[4];
        r[23]    = m_dn;
        r[21:17] = m_en;
        r[12:8]  = m_sticky;
        return r;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // fl lanes: [0] UF, [1] DZ, [2] OV, [3] IV, [4] UI
    task automatic step(string tag, logic d, logic [4:0] fl, logic dop,
                        logic w, logic [31:0] wd);
        logic [4:0] exc;
        logic       tk;
        logic [4:0] keep;
        done = d; uf = fl[0]; dz = fl[1]; ov = fl[2]; iv = fl[3]; ui = fl[4];
        dnm = dop; we = w; wdata = wd;
        exc    = fl;
        exc[4] = fl[4] | (dop & ~m_dn);
        tk     = d & (|(exc & m_en));
        keep   = w ? (m_sticky & wd[12:8]) : m_sticky;
        if (d)      m_cause = exc;
        else if (w) m_cause = m_cause & {wd[25], wd[29], wd[28], wd[27], wd[26]};
        m_sticky = keep | ((d && !tk) ? exc : 5'b0);
        if (w) begin
            m_en = wd[21:17];
            m_dn = wd[23];
            m_rm = wd[31:30];
        end
        m_trap = tk;
        @(posedge clk);
        @(negedge clk);
        check(tag, rdata, exp_word());
        check({tag, " trap"}, {31'b0, trap}, {31'b0, m_trap});
        check({tag, " rm/dn"}, {29'b0, dn_out, rm_out}, {29'b0, m_dn, m_rm});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 rdata", rdata, 32'h0);
        check("R1 trap", {31'b0, trap}, 32'h0);
        check("R1 rm", {30'b0, rm_out}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", rdata, 32'h0);

        // R4 rounding mode toward +infinity
        step("R4 rm=10", 0, 5'b0, 0, 1, 32'h8000_0000);
        check("R4 port", {30'b0, rm_out}, 32'h2);
        // R10 + R3: all ones write: fields set, flags and reserved stay 0
        step("R10 ones", 0, 5'b0, 0, 1, 32'hFFFF_FFFF);
        check("R10 word", rdata, 32'hC0BE_0000);
        step("R4 clear", 0, 5'b0, 0, 1, 32'h4000_0000);
        check("R4 rm=01", {30'b0, rm_out}, 32'h1);
        // R6 masked UF+OV sets sticky, no trap
        step("R6 masked", 1, 5'b00101, 0, 0, 0);
        check("R6 word", rdata, 32'h5400_0500);
        // R2 next op clean wipes cause, sticky persists
        step("R2 wipe", 1, 5'b0, 0, 0, 0);
        check("R2 word", rdata, 32'h4000_0500);
        // R3 ones keep flags; zero at bit 8 clears UF sticky
        step("R3 keep", 0, 5'b0, 0, 1, 32'h7E00_1F00 | 32'h4000_0000);
        step("R3 clear", 0, 5'b0, 0, 1, 32'h4000_1E00);
        check("R3 word", rdata, 32'h4000_0400);
        // R5/R7 enable DZ; DZ+IV traps, IV sticky not set
        step("R5 en", 0, 5'b0, 0, 1, 32'h0004_1F00);
        step("R7 mixed", 1, 5'b01010, 0, 0, 0);
        check("R5 trap", {31'b0, trap}, 32'h1);
        check("R7 sticky", rdata & 32'h1F00, 32'h0400);
        step("R5 pulse end", 0, 5'b0, 0, 0, 0);
        check("R5 low", {31'b0, trap}, 32'h0);
        // R8 denormal with DN=0 -> unimplemented, masked -> sticky
        step("R8 dn0", 1, 5'b0, 1, 0, 0);
        check("R8 ui", rdata & 32'h0200_1000, 32'h0200_1000);
        step("R8 set dn", 0, 5'b0, 0, 1, 32'h0084_1F00);
        step("R8 dn1", 1, 5'b0, 1, 0, 0);
        check("R8 no ui", rdata & 32'h0200_0000, 32'h0);
        // R9 write clearing all plus OV completion in same cycle
        step("R9 collide", 1, 5'b00100, 0, 1, 32'h0000_0000);
        check("R9 word", rdata, 32'h1000_0400);

        // random mix
        for (int i = 0; i < 1500; i++) begin
            logic        d  = ($urandom % 2) == 0;
            logic [4:0]  fl = 5'($urandom) & 5'($urandom);
            logic        dp = ($urandom % 4) == 0;
            logic        w  = ($urandom % 4) == 0;
            logic [31:0] wd = $urandom;
            if (($urandom % 4) != 0) wd = wd | 32'h3E00_1F00;
            step("R2/R3/R5/R6/R7/R9 random", d, fl, dp, w, wd);
        end

        summary();
        $finish;
    end

endmodule